// File: doc/BRIEF.md
# External memory wait-state controller

The controller carries single-word read and write requests from an on-chip requester out to an asynchronous external memory bus. Software divides the external address space into four banks by writing a low and a high bound for each one. A request whose word address falls inside a bank raises that bank's select line. The request then runs as one or two strobe cycles. Their length comes from a per-bank wait count, from an external acknowledge, or from a mix of the two.

All bus activity moves on an I/O clock enable. This enable is the block clock divided by a programmable ratio. Each bank keeps its own settings: read and write wait counts, completion mode, strobe polarities, and bus width. On an 8-bit bank a 16-bit word is split into two byte accesses, and the byte index is appended to the external address.

Top module: `ext_wait_ctrl`

## Requirements
- R1: A request is tested against each bank's inclusive range [low, high]. The lowest-numbered matching bank wins. Its bit of `ext_sel` is high from acceptance to completion, and at most one bit is ever high.
- R2: A request that matches no bank raises no select and no strobe. `req_ready` and `req_err` go high one clock later, with `req_rdata` equal to zero.
- R3: In count mode a strobe lasts (wait+1) I/O periods. Reads take their wait from control bits [2:0] and writes take theirs from bits [5:3].
- R4: Control bits [7:6] pick how a strobe completes: 0 on count expiry, 1 on acknowledge, 2 when both are present, 3 when either is present.
- R5: `ext_ack` passes through two flip-flops and is then sampled only on I/O clock enables.
- R6: The divider register field [2:0] sets the I/O clock ratio. Code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 16, and codes 4 to 7 give 32. `io_ce` is high for one clock in each period, and strobes change only on clocks where `io_ce` is high.
- R7: Control bit 9 (read) and bit 10 (write) set the active level of the strobe: 1 means active high, 0 means active low.
- R8: When control bit 8 is set the bus is 8 bits wide. The access uses `ext_addr`={addr,0} with the low byte first, then {addr,1} with the high byte. Data moves on bits [7:0], each byte gets a full wait sequence, and one idle I/O period separates the two bytes.
- R9: When control bit 8 is clear the bus is 16 bits wide. `ext_addr`={0,addr} and the whole word moves in one strobe.
- R10: A request is accepted when `req_valid` is high while idle and `req_ready` is low. `req_ready` is high for exactly one clock, on the clock edge that ends the final strobe, and `req_rdata` holds the read word at that point (zero for writes).
- R11: `cfg_sel`[3:2] selects a bank and `cfg_sel`[1:0] selects a register: 0 for control, 1 for low bound, 2 for high bound, 3 for the shared divider. After reset every bank is empty. A bank's control value is latched when a request is accepted, so a later write does not change an access already in flight.
- R12: `ext_doe` is high for the whole of a write access and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Bank and register select |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write word |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read word |
| req_err | output | 1 | Request matched no bank |
| io_ce | output | 1 | I/O clock enable |
| ext_sel | output | 4 | Active-high bank selects |
| ext_addr | output | 17 | External address |
| ext_rd | output | 1 | Read strobe, polarity per bank |
| ext_wr | output | 1 | Write strobe, polarity per bank |
| ext_dout | output | 16 | External write data |
| ext_doe | output | 1 | Write data drive enable |
| ext_din | input | 16 | External read data |
| ext_ack | input | 1 | External acknowledge |

## Verification
Results arrive at different delays. A miss completes on the first clock edge after the request appears. The select goes high one clock after acceptance. A strobe starts on the next clock where `io_ce` is high and ends on a later such clock. `req_ready` is raised on that same ending edge. A change on `ext_ack` can end a strobe no earlier than the first enable that falls two or more clocks after the change. The bench's behavioural model advances on the same rising edges, and every output is compared at the falling edge that follows. A short directed set of checks also counts strobe clocks against hand-worked totals: (wait+1) times the ratio, doubled for byte mode, and 8 clocks for the acknowledge case at ratio 4.

// File: rtl/ext_wait_ctrl.sv
module ext_wait_ctrl #(
  parameter int AW = 16,
  parameter int NB = 4,
  parameter int CW = (AW > 11) ? AW : 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NB)+1:0]   cfg_sel,
  input  logic [CW-1:0]           cfg_wdata,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic [AW-1:0]           req_addr,
  input  logic [15:0]             req_wdata,
  output logic                    req_ready,
  output logic [15:0]             req_rdata,
  output logic                    req_err,
  output logic                    io_ce,
  output logic [NB-1:0]           ext_sel,
  output logic [AW:0]             ext_addr,
  output logic                    ext_rd,
  output logic                    ext_wr,
  output logic [15:0]             ext_dout,
  output logic                    ext_doe,
  input  logic [15:0]             ext_din,
  input  logic                    ext_ack
);
  localparam int BW = $clog2(NB);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_STRB} st_t;

  logic [10:0]   ctrl_q [NB];
  logic [AW-1:0] lo_q   [NB];
  logic [AW-1:0] hi_q   [NB];
  logic [2:0]    div_q;

  logic [BW-1:0] cfg_bank;
  logic [1:0]    cfg_reg;
  assign cfg_bank = cfg_sel[BW+1:2];
  assign cfg_reg  = cfg_sel[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      for (int i = 0; i < NB; i++) begin
        ctrl_q[i] <= '0;
        lo_q[i]   <= '1;
        hi_q[i]   <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_reg)
        2'd0:    ctrl_q[cfg_bank] <= cfg_wdata[10:0];
        2'd1:    lo_q[cfg_bank]   <= cfg_wdata[AW-1:0];
        2'd2:    hi_q[cfg_bank]   <= cfg_wdata[AW-1:0];
        default: div_q            <= cfg_wdata[2:0];
      endcase
    end
  end

  logic          hit;
  logic [BW-1:0] hit_idx;
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NB-1; i >= 0; i--) begin
      if (req_addr >= lo_q[i] && req_addr <= hi_q[i]) begin
        hit     = 1'b1;
        hit_idx = BW'(i);
      end
    end
  end

  logic [4:0] div_cnt, div_top;
  always_comb begin
    case (div_q)
      3'd0:    div_top = 5'd0;
      3'd1:    div_top = 5'd1;
      3'd2:    div_top = 5'd3;
      3'd3:    div_top = 5'd15;
      default: div_top = 5'd31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_cnt <= '0;
    else if (div_cnt == '0)  div_cnt <= div_top;
    else                     div_cnt <= div_cnt - 5'd1;
  end
  assign io_ce = (div_cnt == '0);

  logic ack_m, ack_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= ext_ack;
      ack_s <= ack_m;
    end
  end

  st_t           st;
  logic [BW-1:0] cur_bank;
  logic [10:0]   cur_ctrl;
  logic          cur_we, byte_q;
  logic [AW-1:0] cur_addr;
  logic [15:0]   cur_wdata, rdata_q;
  logic [2:0]    cnt_q;
  logic          ready_q, err_q;

  logic [1:0] mode;
  logic       bus8, rd_pol, wr_pol, expired, done, last;
  assign mode    = cur_ctrl[7:6];
  assign bus8    = cur_ctrl[8];
  assign rd_pol  = cur_ctrl[9];
  assign wr_pol  = cur_ctrl[10];
  assign expired = (cnt_q == '0);
  assign last    = !bus8 || byte_q;

  always_comb begin
    case (mode)
      2'd0:    done = expired;
      2'd1:    done = ack_s;
      2'd2:    done = expired && ack_s;
      default: done = expired || ack_s;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_bank  <= '0;
      cur_ctrl  <= '0;
      cur_we    <= 1'b0;
      byte_q    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rdata_q   <= '0;
      cnt_q     <= '0;
      ready_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid && !ready_q) begin
            if (hit) begin
              st        <= S_ARM;
              cur_bank  <= hit_idx;
              cur_ctrl  <= ctrl_q[hit_idx];
              cur_we    <= req_we;
              cur_addr  <= req_addr;
              cur_wdata <= req_wdata;
              byte_q    <= 1'b0;
              rdata_q   <= '0;
            end else begin
              ready_q <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '0;
            end
          end
        end
        S_ARM: begin
          if (io_ce) begin
            st    <= S_STRB;
            cnt_q <= cur_we ? cur_ctrl[5:3] : cur_ctrl[2:0];
          end
        end
        default: begin
          if (io_ce) begin
            if (done) begin
              if (!cur_we) begin
                if (!bus8)       rdata_q        <= ext_din;
                else if (byte_q) rdata_q[15:8] <= ext_din[7:0];
                else             rdata_q[7:0]  <= ext_din[7:0];
              end
              if (last) begin
                st      <= S_IDLE;
                ready_q <= 1'b1;
                err_q   <= 1'b0;
              end else begin
                byte_q <= 1'b1;
                st     <= S_ARM;
              end
            end else if (!expired) begin
              cnt_q <= cnt_q - 3'd1;
            end
          end
        end
      endcase
    end
  end

  logic busy, rd_act, wr_act;
  assign busy   = (st != S_IDLE);
  assign rd_act = (st == S_STRB) && !cur_we;
  assign wr_act = (st == S_STRB) && cur_we;

  for (genvar g = 0; g < NB; g++) begin : g_sel
    assign ext_sel[g] = busy && (cur_bank == BW'(g));
  end

  assign ext_rd    = rd_pol ? rd_act : !rd_act;
  assign ext_wr    = wr_pol ? wr_act : !wr_act;
  assign ext_addr  = bus8 ? {cur_addr, byte_q} : {1'b0, cur_addr};
  assign ext_dout  = bus8 ? {8'h00, (byte_q ? cur_wdata[15:8] : cur_wdata[7:0])} : cur_wdata;
  assign ext_doe   = busy && cur_we;
  assign req_ready = ready_q;
  assign req_rdata = rdata_q;
  assign req_err   = err_q;
endmodule

// File: rtl/ext_wait_ctrl_sva.sv
module ext_wait_ctrl_sva #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_ce,
  input logic [NB-1:0] ext_sel,
  input logic          rd_act,
  input logic          wr_act,
  input logic          ext_doe,
  input logic          req_ready,
  input logic          req_err,
  input logic [15:0]   req_rdata
);
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_sel));

  p_strobe_in_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act || wr_act) |-> (ext_sel != '0));

  p_miss_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_err) |-> (ext_sel == '0 && req_rdata == 16'h0000));

  p_strobe_on_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !io_ce |=> ($stable(rd_act) && $stable(wr_act)));

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  p_doe_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act |-> ext_doe) and (rd_act |-> !ext_doe));
endmodule

bind ext_wait_ctrl ext_wait_ctrl_sva #(.NB(NB)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_ce    (io_ce),
  .ext_sel  (ext_sel),
  .rd_act   (rd_act),
  .wr_act   (wr_act),
  .ext_doe  (ext_doe),
  .req_ready(req_ready),
  .req_err  (req_err),
  .req_rdata(req_rdata)
);

// File: tb/tb_ext_wait_ctrl.sv
module tb_ext_wait_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, req_err, io_ce, ext_rd, ext_wr, ext_doe;
  logic [15:0] req_rdata, ext_dout, ext_din;
  logic [3:0]  ext_sel;
  logic [16:0] ext_addr;
  logic        ext_ack = 1'b0;

  int checks = 0, errors = 0;
  bit t_rp = 1'b0, t_wp = 1'b0;
  int ack_lat = 1000, acnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem(input logic [16:0] a);
    logic [31:0] t;
    t = {15'd0, a} * 32'd40503 + 32'd4660;
    return t[15:0] ^ t[31:16];
  endfunction

  assign ext_din = mem(ext_addr);

  ext_wait_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata), .req_err(req_err), .io_ce(io_ce),
    .ext_sel(ext_sel), .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din), .ext_ack(ext_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit strobe_on();
    return (ext_rd != !t_rp) || (ext_wr != !t_wp);
  endfunction

  // external acknowledge responder
  always @(negedge clk) begin
    if (rst_n && strobe_on()) acnt++;
    else acnt = 0;
    ext_ack = (acnt >= ack_lat);
  end

  // behavioural reference model
  logic [10:0] m_ctrl [4];
  logic [15:0] m_lo [4], m_hi [4];
  int          m_div, m_dc, m_ph, m_bank, m_cnt;
  bit          m_a1, m_a2, m_we, m_byte, m_rdy, m_err;
  logic [10:0] m_c;
  logic [15:0] m_addr, m_wd, m_rd;

  function automatic int div_top(input int code);
    case (code)
      0: return 0;
      1: return 1;
      2: return 3;
      3: return 15;
      default: return 31;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_ctrl[i] = '0; m_lo[i] = 16'hFFFF; m_hi[i] = '0;
      end
      m_div = 0; m_dc = 0; m_ph = 0; m_bank = 0; m_cnt = 0;
      m_a1 = 0; m_a2 = 0; m_we = 0; m_byte = 0; m_rdy = 0; m_err = 0;
      m_c = '0; m_addr = '0; m_wd = '0; m_rd = '0;
    end else begin
      bit ce, ak, rdy_old, fin;
      int hb;
      ce = (m_dc == 0);
      ak = m_a2;
      rdy_old = m_rdy;
      m_rdy = 0;
      if (m_ph == 0) begin
        if (req_valid && !rdy_old) begin
          hb = -1;
          for (int i = 0; i < 4; i++)
            if (hb < 0 && req_addr >= m_lo[i] && req_addr <= m_hi[i]) hb = i;
          if (hb < 0) begin
            m_rdy = 1; m_err = 1; m_rd = '0;
          end else begin
            m_ph = 1; m_bank = hb; m_c = m_ctrl[hb]; m_we = req_we;
            m_addr = req_addr; m_wd = req_wdata; m_byte = 0; m_rd = '0;
          end
        end
      end else if (m_ph == 1) begin
        if (ce) begin
          m_ph = 2;
          m_cnt = m_we ? int'(m_c[5:3]) : int'(m_c[2:0]);
        end
      end else if (ce) begin
        case (m_c[7:6])
          2'd0: fin = (m_cnt == 0);
          2'd1: fin = ak;
          2'd2: fin = (m_cnt == 0) && ak;
          default: fin = (m_cnt == 0) || ak;
        endcase
        if (fin) begin
          if (!m_we) begin
            if (!m_c[8]) m_rd = ext_din;
            else if (m_byte) m_rd[15:8] = ext_din[7:0];
            else m_rd[7:0] = ext_din[7:0];
          end
          if (m_c[8] && !m_byte) begin
            m_byte = 1; m_ph = 1;
          end else begin
            m_ph = 0; m_rdy = 1; m_err = 0;
          end
        end else if (m_cnt > 0) m_cnt--;
      end
      if (m_dc == 0) m_dc = div_top(m_div); else m_dc--;
      m_a2 = m_a1;
      m_a1 = ext_ack;
      if (cfg_we) begin
        case (cfg_sel[1:0])
          2'd0: m_ctrl[cfg_sel[3:2]] = cfg_wdata[10:0];
          2'd1: m_lo[cfg_sel[3:2]] = cfg_wdata;
          2'd2: m_hi[cfg_sel[3:2]] = cfg_wdata;
          default: m_div = int'(cfg_wdata[2:0]);
        endcase
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0]  e_sel;
      logic [16:0] e_addr;
      logic [15:0] e_dout;
      bit rd_on, wr_on;
      e_sel  = (m_ph != 0) ? 4'(1 << m_bank) : 4'h0;
      rd_on  = (m_ph == 2) && !m_we;
      wr_on  = (m_ph == 2) && m_we;
      e_addr = m_c[8] ? {m_addr, m_byte} : {1'b0, m_addr};
      e_dout = m_c[8] ? {8'h00, (m_byte ? m_wd[15:8] : m_wd[7:0])} : m_wd;
      chk(ext_sel == e_sel, "R1 select", 32'(ext_sel), 32'(e_sel));
      chk(ext_rd == (m_c[9] ? rd_on : !rd_on), "R4 R5 R7 read strobe", 32'(ext_rd), 32'(m_c[9] ? rd_on : !rd_on));
      chk(ext_wr == (m_c[10] ? wr_on : !wr_on), "R4 R7 write strobe", 32'(ext_wr), 32'(m_c[10] ? wr_on : !wr_on));
      chk(io_ce == (m_dc == 0), "R6 io_ce", 32'(io_ce), 32'(m_dc == 0));
      chk(ext_doe == ((m_ph != 0) && m_we), "R12 ext_doe", 32'(ext_doe), 32'((m_ph != 0) && m_we));
      if (m_ph != 0) begin
        chk(ext_addr == e_addr, "R8 R9 ext_addr", 32'(ext_addr), 32'(e_addr));
        chk(ext_dout == e_dout, "R8 R9 ext_dout", 32'(ext_dout), 32'(e_dout));
      end
      chk(req_ready == m_rdy, "R10 req_ready", 32'(req_ready), 32'(m_rdy));
      chk(req_err == m_err, "R2 req_err", 32'(req_err), 32'(m_err));
      chk(req_rdata == m_rd, "R8 req_rdata", 32'(req_rdata), 32'(m_rd));
    end
  end

  function automatic logic [15:0] mk(input int rw, input int ww, input int md,
                                     input bit b8, input bit rp, input bit wp);
    return {5'd0, wp, rp, b8, 2'(md), 3'(ww), 3'(rw)};
  endfunction

  task automatic cfg(input int bank, input int sub, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(bank * 4 + sub); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [15:0] wd,
                        input bit b8, input int exp_strb, input bit exp_err, input string tag);
    int strb = 0, n = 0;
    logic [15:0] lo, hi, expd;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    do begin
      @(negedge clk);
      n++;
      if (strobe_on()) strb++;
    end while (!req_ready && n < 5000);
    req_valid = 1'b0;
    chk(n < 5000, {tag, " R10 completion"}, 32'(n), 32'(0));
    chk(req_err == exp_err, {tag, " R2 error flag"}, 32'(req_err), 32'(exp_err));
    if (exp_err) expd = 16'h0000;
    else if (we) expd = 16'h0000;
    else if (b8) begin
      lo = mem({a, 1'b0}); hi = mem({a, 1'b1});
      expd = {hi[7:0], lo[7:0]};
    end else expd = mem({1'b0, a});
    chk(req_rdata == expd, {tag, " R8 R9 data word"}, 32'(req_rdata), 32'(expd));
    if (exp_strb >= 0) chk(strb == exp_strb, {tag, " R3 strobe clocks"}, 32'(strb), 32'(exp_strb));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ext_sel == 4'h0 && !req_ready && !ext_doe, "R11 reset idle", {ext_sel, req_ready, ext_doe}, 32'h0);
    chk(ext_rd && ext_wr && io_ce, "R11 reset strobes", {ext_rd, ext_wr, io_ce}, 32'h7);
    rst_n = 1'b1;

    access(1'b0, 16'h0100, 16'h0, 1'b0, 0, 1'b1, "R2 R11 empty banks");
    cfg(0, 1, 16'h0000); cfg(0, 2, 16'h0FFF); cfg(0, 0, mk(2, 5, 0, 0, 0, 0));
    access(1'b1, 16'h0123, 16'hBEEF, 1'b0, 6, 1'b0, "R3 R9 write wait 5");
    access(1'b0, 16'h0456, 16'h0, 1'b0, 3, 1'b0, "R3 R9 read wait 2");

    cfg(0, 3, 16'd1);
    cfg(1, 1, 16'h1000); cfg(1, 2, 16'h1FFF); cfg(1, 0, mk(0, 1, 0, 1, 1, 1));
    t_rp = 1; t_wp = 1;
    access(1'b1, 16'h1234, 16'hA55A, 1'b1, 8, 1'b0, "R7 R8 byte write");
    access(1'b0, 16'h1235, 16'h0, 1'b1, 4, 1'b0, "R7 R8 byte read");
    t_rp = 0; t_wp = 0;

    cfg(0, 3, 16'd2);
    cfg(2, 1, 16'h2000); cfg(2, 2, 16'h2FFF); cfg(2, 0, mk(0, 0, 1, 0, 0, 0));
    ack_lat = 3;
    access(1'b0, 16'h2100, 16'h0, 1'b0, 8, 1'b0, "R5 R4 ack sync");
    access(1'b1, 16'h2200, 16'h1357, 1'b0, -1, 1'b0, "R4 ack write");

    cfg(0, 3, 16'd0);
    cfg(3, 1, 16'h0800); cfg(3, 2, 16'h3FFF); cfg(3, 0, mk(4, 4, 2, 0, 0, 0));
    ack_lat = 1;
    access(1'b0, 16'h0900, 16'h0, 1'b0, 3, 1'b0, "R1 overlap priority");
    access(1'b0, 16'h3000, 16'h0, 1'b0, 5, 1'b0, "R4 and mode");

    cfg(0, 3, 16'd4);
    cfg(3, 0, mk(7, 7, 3, 0, 0, 0));
    ack_lat = 2;
    access(1'b0, 16'h3001, 16'h0, 1'b0, 32, 1'b0, "R4 or mode");
    access(1'b1, 16'h5000, 16'h0, 1'b0, 0, 1'b1, "R2 write miss");
    ack_lat = 1000;

    cfg(0, 3, 16'd3);
    access(1'b0, 16'h0010, 16'h0, 1'b0, 48, 1'b0, "R6 ratio 16");
    cfg(0, 3, 16'd7);
    access(1'b0, 16'h0011, 16'h0, 1'b0, 96, 1'b0, "R6 ratio 32");

    cfg(0, 3, 16'd3);
    fork
      access(1'b0, 16'h0020, 16'h0, 1'b0, 48, 1'b0, "R11 latched control");
      begin
        repeat (10) @(negedge clk);
        cfg(0, 0, mk(7, 7, 0, 0, 0, 0));
      end
    join
    access(1'b0, 16'h0021, 16'h0, 1'b0, 128, 1'b0, "R11 new control");
    access(1'b0, 16'hFFFF, 16'h0, 1'b0, 0, 1'b1, "R2 top address miss");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule